// File: doc/BRIEF.md
# Transmit Phase Compensation Buffer

This block moves parallel data words from the fabric interface clock into the transceiver's low-speed parallel clock. The two clocks run at the same rate, but their phase relation is unknown. A small dual-clock FIFO absorbs that phase offset. The FIFO uses Gray-coded pointers, and each pointer crosses into the other domain through a two-flop synchronizer. The full flag is worked out in the write domain and the empty flag in the read domain. Both flags err on the safe side, so the buffer can neither overflow nor underflow.

After reset, the read side reports empty until two words have been written. This gives the read pointer a margin of one word behind the write pointer. A write attempted while the buffer is full is discarded and latches an overflow error. A read attempted while it is empty leaves the output word unchanged and latches an underflow error.

A static mode input, sampled only while the block is held in reset, can select register mode instead. In this mode the FIFO storage is not used. Every word is captured by a single register on the read clock, which gives a fixed latency for protocols that need deterministic timing. Register mode requires a read clock with a fixed, known phase relative to the write clock.

Top module: `pcomp_fifo`

## Requirements
- R1: While both resets are held, rd_data is 0, full, overflow and underflow are 0, and empty equals the inverse of reg_mode.
- R2: In FIFO mode (reg_mode sampled 0), accepted words appear on rd_data in write order, with no loss and no duplication. A read is accepted when rd_en is 1 and empty is 0, and the word appears at that same read edge.
- R3: full is 1 whenever 8 unread words are held. A write with wr_en 1 while full is 1 is discarded, and overflow becomes 1 at that write edge.
- R4: A read with rd_en 1 while empty is 1 leaves rd_data unchanged, and underflow becomes 1 at that read edge.
- R5: After reset in FIFO mode, empty stays 1 while fewer than 2 words have been written.
- R6: Once the buffer is primed, empty falls no later than the third read-clock rising edge after the write edge of a word.
- R7: empty at 0 implies at least one unread word, and full at 0 implies fewer than 8 unread words.
- R8: In register mode, rd_data takes wr_data at each read edge where wr_en is 1 and holds otherwise. rd_en has no effect, and full, empty, overflow and underflow stay 0.
- R9: A change of reg_mode outside reset has no effect until the next reset.
- R10: overflow and underflow stay set until the next reset and clear in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Fabric-side write clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Word to write |
| full | output | 1 | No room for another word (write domain) |
| overflow | output | 1 | Sticky: a write was dropped |
| rd_clk | input | 1 | Transceiver parallel read clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Registered output word |
| empty | output | 1 | No readable word (read domain) |
| underflow | output | 1 | Sticky: a read found nothing |
| reg_mode | input | 1 | 1 selects register mode; sampled in reset |

## Verification
A corrupted pointer or synchronizer stage shows up at the ports as a wrong, repeated or skipped word on rd_data. Because the bench compares rd_data at every read edge, the fault is caught at the first read that follows it. A wrong flag computation shows up within one cycle: empty falls while the reference queue is empty, full stays low with eight words held, or a sticky error bit moves when it should not. A mode register that follows the pin outside reset changes the output within a cycle of the pin change, because the capture behaviour differs between the two modes.

// File: rtl/pcomp_fifo.sv
module pcomp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int PRIME = 2
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         overflow,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         underflow,
  input  logic         reg_mode
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];

  // write domain
  logic          wmode;
  logic [PW-1:0] wbin, wgray, wq1, wq2;
  logic [PW-1:0] rgray;

  always_ff @(posedge wr_clk)
    if (!wr_rst_n) wmode <= reg_mode;

  wire [PW-1:0] wbin_nx = wbin + 1'b1;
  assign full = !wmode && (wgray == {~wq2[PW-1:PW-2], wq2[PW-3:0]});
  wire wpush = wr_en && !full && !wmode;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin <= '0; wgray <= '0; wq1 <= '0; wq2 <= '0; overflow <= 1'b0;
    end else begin
      wq1 <= rgray;
      wq2 <= wq1;
      if (wpush) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wr_en && full) overflow <= 1'b1;
    end

  always_ff @(posedge wr_clk)
    if (wpush) mem[wbin[AW-1:0]] <= wr_data;

  // read domain
  logic          rmode, primed;
  logic [PW-1:0] rbin, rq1, rq2;

  always_ff @(posedge rd_clk)
    if (!rd_rst_n) rmode <= reg_mode;

  wire [PW-1:0] fill    = g2b(rq2) - rbin;
  wire [PW-1:0] rbin_nx = rbin + 1'b1;
  assign empty = !rmode && ((rgray == rq2) || (!primed && fill < PW'(PRIME)));
  wire rpop = rd_en && !empty && !rmode;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin <= '0; rgray <= '0; rq1 <= '0; rq2 <= '0;
      primed <= 1'b0; underflow <= 1'b0; rd_data <= '0;
    end else begin
      rq1 <= wgray;
      rq2 <= rq1;
      if (!primed && fill >= PW'(PRIME)) primed <= 1'b1;
      if (rmode) begin
        if (wr_en) rd_data <= wr_data;
      end else if (rpop) begin
        rd_data <= mem[rbin[AW-1:0]];
        rbin    <= rbin_nx;
        rgray   <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (rd_en && empty) underflow <= 1'b1;
    end

  // checks
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_en && full |=> $stable(wbin));                                   // R3
  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    overflow |=> overflow);                                             // R10
  AST_OCCUPANCY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wbin - g2b(wq2)) <= PW'(DEPTH));                                   // R7
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);                             // R2
  AST_WMODE_HELD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $stable(wmode));                                                    // R9
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en && empty |=> $stable(rd_data) && $stable(rbin));              // R4
  AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    underflow |=> underflow);                                           // R10
  AST_REG_QUIET: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rmode |-> !empty && !underflow);                                    // R8
endmodule

// File: tb/tb_pcomp_fifo.sv
module tb_pcomp_fifo;
  localparam int W = 16, DEPTH = 8;

  logic wr_clk = 0, rd_clk = 1, rst_n = 0, mode = 0;
  logic wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic full, overflow, empty, underflow;
  logic [W-1:0] rd_data;

  pcomp_fifo #(.W(W), .DEPTH(DEPTH), .PRIME(2)) dut (
    .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .overflow(overflow),
    .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .underflow(underflow), .reg_mode(mode));

  initial forever #10 wr_clk = ~wr_clk;
  initial begin #7; forever begin rd_clk = ~rd_clk; #10; end end

  int vectors = 0, fails = 0, cyc = 0;
  int wr_mode = 0, rd_mode = 0, wr_budget = 0;
  logic m_mode = 0, exp_ovf = 0, exp_unf = 0;
  logic [W-1:0] exp_rd = '0, wcnt = 16'h1000;
  logic [W-1:0] q[$];

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, expv);
    end
  endtask

  always @(negedge wr_clk) begin
    cyc++;
    if (!rst_n) begin
      wr_en = 0; q.delete(); exp_ovf = 0; m_mode = mode;
    end else begin
      logic want;
      chk(overflow == exp_ovf, "R3/R10 overflow", overflow, exp_ovf);
      if (m_mode) chk(full == 0, "R8 full quiet", full, 0);
      else begin
        if (!full) chk(q.size() < DEPTH, "R7 full conservative", q.size(), DEPTH - 1);
        if (q.size() == DEPTH) chk(full == 1, "R3 full at 8", full, 1);
      end
      want = (wr_mode == 1) || (wr_mode == 3) || (wr_mode == 2 && ((cyc * 7) % 5) < 3);
      if (wr_mode == 0 && wr_budget > 0) begin want = 1; wr_budget--; end
      if (wr_mode != 3 && !m_mode && full) want = 0;
      wr_en = want;
      if (want) begin
        wr_data = wcnt; wcnt++;
        if (!m_mode) begin
          if (full) exp_ovf = 1;
          else q.push_back(wr_data);
        end
      end
    end
  end

  always @(negedge rd_clk) begin
    if (!rst_n) begin
      rd_en = 0; exp_rd = '0; exp_unf = 0;
    end else begin
      logic want;
      chk(rd_data == exp_rd, m_mode ? "R8 register path" : "R2 data order", rd_data, exp_rd);
      chk(underflow == exp_unf, "R4/R10 underflow", underflow, exp_unf);
      if (m_mode) chk(empty == 0, "R8 empty quiet", empty, 0);
      else if (!empty) chk(q.size() > 0, "R7 empty conservative", q.size(), 1);
      want = (rd_mode == 1) || (rd_mode == 3) || (rd_mode == 2 && ((cyc * 3) % 7) < 4);
      if (rd_mode != 3 && empty && !m_mode) want = 0;
      rd_en = want;
      if (m_mode) begin
        if (wr_en) exp_rd = wr_data;
      end else if (want) begin
        if (empty) exp_unf = 1;
        else exp_rd = q.pop_front();
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge wr_clk);
    #2;
  endtask

  task automatic do_reset(input logic md);
    step(1);
    wr_mode = 0; rd_mode = 0; mode = md; rst_n = 0;
    step(4);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);
    chk(full == 0, "R1 full", full, 0);
    chk(overflow == 0, "R1/R10 overflow clear", overflow, 0);
    chk(underflow == 0, "R1/R10 underflow clear", underflow, 0);
    chk(empty == !md, "R1 empty", empty, !md);
    rst_n = 1;
  endtask

  initial begin
    do_reset(0);
    // R5 hold-off with a single word
    step(2); wr_budget = 1; step(15);
    chk(empty == 1, "R5 hold-off", empty, 1);
    wr_budget = 1;
    @(posedge wr_clk);
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty == 0, "R6 empty latency", empty, 0);
    step(1);
    rd_mode = 1; step(10);
    // R2 mixed traffic
    wr_mode = 2; rd_mode = 2; step(300);
    wr_mode = 0; rd_mode = 1; step(30);
    chk(q.size() == 0, "R2 drained", q.size(), 0);
    chk(empty == 1, "R2 empty after drain", empty, 1);
    // R3 overflow
    rd_mode = 0; wr_mode = 3; step(14);
    wr_mode = 0; step(2);
    chk(overflow == 1, "R3 overflow set", overflow, 1);
    rd_mode = 1; step(30);
    // R4 underflow
    rd_mode = 3; step(4);
    rd_mode = 0; step(2);
    chk(underflow == 1, "R4 underflow set", underflow, 1);
    // R9 mode pin change ignored outside reset
    mode = 1; wr_mode = 2; rd_mode = 2; step(100);
    wr_mode = 0; rd_mode = 1; step(30);
    chk(empty == 1, "R9 still FIFO mode", empty, 1);
    chk(overflow == 1, "R10 overflow held", overflow, 1);
    // R8 register mode
    do_reset(1);
    wr_mode = 2; rd_mode = 3; step(100);
    mode = 0; step(50);
    chk(empty == 0, "R9 still register mode", empty, 0);
    wr_mode = 0; rd_mode = 0;
    do_reset(0);
    step(3);
    chk(empty == 1, "R1 back to FIFO mode", empty, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule